// File: doc/BRIEF.md
# Fixed-Point Time-of-Day Counter

This block keeps a 64-bit time-of-day value that moves forward by a programmable fixed-point step on each reference clock cycle. It does not count whole nanoseconds. Software chooses the step so that the nanosecond value is the count shifted right by a fixed amount. For example, a 6.4 ns reference with step 0x66666666 gives nanoseconds = count >> 28. At 64 ns the step is 0x40000000 with shift 24, and at 640 ns it is 0x50000000 with shift 21. Software trims the frequency by rewriting the step, and the running count is not disturbed.

A small host register port holds the step register and the two 32-bit halves of the time. A parameter selects one of two step layouts:
- **Wide:** a 31-bit step.
- **Narrow:** a 24-bit step plus an 8-bit period field. The period field is normally programmed to 1. In this layout software reduces both the step and the shift by 7 bits.

Reading the low half freezes a copy of the high half, so a low-then-high read pair is coherent across a carry. Writing the low half only stages it. The following high write loads both halves in one cycle.

Top module: `tod_counter`

## Requirements
- R1: After reset the count is 0 and `reg_rdata` is 0. The step register holds `RST_INCR`, which defaults to 0x66666666 in wide layout and 0x01CCCCCC in narrow layout.
- R2: On each cycle in which a step is due, the count increases by the step field. The sum wraps modulo 2^64.
- R3: Register addresses are 0 for the step register, 1 for the low half and 2 for the high half. Address 3 reads as 0 and ignores writes. Read data is registered and is valid in the cycle after the read strobe.
- R4: In wide layout the step is bits 30:0, and bit 31 is dropped on write and reads as 0. In narrow layout the step is bits 23:0 and the period is bits 31:24. All 32 bits read back.
- R5: In narrow layout with period P ≠ 0, a step is due once every P cycles, counted from the step-register write. The first step falls P cycles after that write. With P = 0 the count holds.
- R6: A step-register write does not alter the count. In the write cycle the count still advances by the old step, and the new step applies from the next cycle.
- R7: A write to the low half leaves the count unchanged. The value is held until a high write.
- R8: A write to the high half loads {written high, held low} into the count in that cycle, in place of that cycle's advance.
- R9: A low-half read returns bits 31:0 of the count at that clock edge and captures bits 63:32 into a shadow. A high-half read returns the shadow, not the live high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the count may advance on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 step, 1 low half, 2 high half |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A table of load values drives both layouts at once. Each row is followed by a chosen number of idle cycles. The rows are built to separate four behaviours:
- a plain advance;
- a carry from the low half into the high half;
- a full 64-bit wrap;
- a long run in which the step is multiplied many times.

Directed sequences then cover three further cases:
- Step rewrite timing: the old step must still apply in the write cycle.
- Period layouts: a period of 0 must freeze the count and a period of 3 must space the steps.
- Ignored and staged writes, observed through the count.

A low read followed by a high read across a carry shows whether the high value comes from the shadow or from the live count.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int TOD_WORD_W       = 32;
    localparam int TOD_CNT_W        = 64;
    localparam int TOD_WIDE_INC_W   = 31;
    localparam int TOD_NARROW_INC_W = 24;
    localparam int TOD_PER_LSB      = 24;
    localparam int TOD_PER_W        = 8;

    typedef enum logic [1:0] {
        TOD_A_INCR = 2'd0,
        TOD_A_LOW  = 2'd1,
        TOD_A_HIGH = 2'd2,
        TOD_A_NONE = 2'd3
    } tod_addr_e;
endpackage

// File: rtl/tod_regif.sv
module tod_regif
    import tod_pkg::*;
#(
    parameter bit                    NARROW   = 1'b0,
    parameter logic [TOD_WORD_W-1:0] RST_INCR = 32'h6666_6666
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [1:0]            reg_addr,
    input  logic [TOD_WORD_W-1:0] reg_wdata,
    input  logic [TOD_CNT_W-1:0]  count_i,
    output logic [TOD_WORD_W-1:0] reg_rdata,
    output logic [TOD_WORD_W-1:0] incr_reg_o,
    output logic                  incr_wr_o,
    output logic                  load_o,
    output logic [TOD_CNT_W-1:0]  load_val_o,
    output logic [TOD_WORD_W-1:0] shadow_o
);
    localparam logic [TOD_WORD_W-1:0] INCR_MASK =
        NARROW ? {TOD_WORD_W{1'b1}}
               : TOD_WORD_W'((64'd1 << TOD_WIDE_INC_W) - 64'd1);

    typedef struct packed {
        logic [TOD_WORD_W-1:0] incr;
        logic [TOD_WORD_W-1:0] pend_low;
        logic [TOD_WORD_W-1:0] shadow;
        logic [TOD_WORD_W-1:0] rdata;
    } regif_st_t;

    regif_st_t st_d, st_q;
    tod_addr_e addr;

    assign addr = tod_addr_e'(reg_addr);

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (addr)
                TOD_A_INCR: st_d.incr     = reg_wdata & INCR_MASK;
                TOD_A_LOW:  st_d.pend_low = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd) begin
            case (addr)
                TOD_A_INCR: st_d.rdata = st_q.incr;
                TOD_A_LOW: begin
                    st_d.rdata  = count_i[TOD_WORD_W-1:0];
                    st_d.shadow = count_i[TOD_CNT_W-1:TOD_WORD_W];
                end
                TOD_A_HIGH: st_d.rdata = st_q.shadow;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.incr     <= RST_INCR & INCR_MASK;
            st_q.pend_low <= '0;
            st_q.shadow   <= '0;
            st_q.rdata    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = st_q.rdata;
    assign incr_reg_o = st_q.incr;
    assign shadow_o   = st_q.shadow;
    assign incr_wr_o  = reg_wr && (addr == TOD_A_INCR);
    assign load_o     = reg_wr && (addr == TOD_A_HIGH);
    assign load_val_o = {reg_wdata, st_q.pend_low};
endmodule

// File: rtl/tod_step.sv
module tod_step
    import tod_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TOD_WORD_W-1:0] incr_reg,
    input  logic                  restart,
    output logic                  step_o,
    output logic [TOD_CNT_W-1:0]  addend_o
);
    generate
        if (NARROW) begin : g_narrow
            typedef struct packed {
                logic [TOD_PER_W-1:0] cnt;
            } div_st_t;

            div_st_t              div_d, div_q;
            logic [TOD_PER_W-1:0] period;
            logic                 due;

            assign period   = incr_reg[TOD_PER_LSB +: TOD_PER_W];
            assign due      = (period != '0) && (div_q.cnt >= (period - TOD_PER_W'(1)));
            assign addend_o = TOD_CNT_W'(incr_reg[TOD_NARROW_INC_W-1:0]);
            assign step_o   = due;

            always_comb begin
                div_d = div_q;
                if (restart || period == '0 || due) begin
                    div_d.cnt = '0;
                end else begin
                    div_d.cnt = div_q.cnt + TOD_PER_W'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
        end else begin : g_wide
            logic unused_wide;
            assign unused_wide = &{1'b0, clk, rst_n, restart, incr_reg[TOD_WORD_W-1]};
            assign step_o      = 1'b1;
            assign addend_o    = TOD_CNT_W'(incr_reg[TOD_WIDE_INC_W-1:0]);
        end
    endgenerate
endmodule

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [TOD_CNT_W-1:0] addend,
    input  logic                 load,
    input  logic [TOD_CNT_W-1:0] load_val,
    output logic [TOD_CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [TOD_CNT_W-1:0] count;
    } acc_st_t;

    acc_st_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load)      acc_d.count = load_val;
        else if (step) acc_d.count = acc_q.count + addend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count_o = acc_q.count;
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter bit          NARROW   = 1'b0,
    parameter logic [31:0] RST_INCR = NARROW ? 32'h01CC_CCCC : 32'h6666_6666
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic [TOD_CNT_W-1:0]  count_w;
    logic [TOD_CNT_W-1:0]  addend_w;
    logic [TOD_CNT_W-1:0]  load_val_w;
    logic [TOD_WORD_W-1:0] incr_w;
    logic [TOD_WORD_W-1:0] shadow_w;
    logic                  incr_wr_w;
    logic                  load_w;
    logic                  step_w;

    tod_regif #(.NARROW(NARROW), .RST_INCR(RST_INCR)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .count_i    (count_w),
        .reg_rdata  (reg_rdata),
        .incr_reg_o (incr_w),
        .incr_wr_o  (incr_wr_w),
        .load_o     (load_w),
        .load_val_o (load_val_w),
        .shadow_o   (shadow_w)
    );

    tod_step #(.NARROW(NARROW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .incr_reg (incr_w),
        .restart  (incr_wr_w),
        .step_o   (step_w),
        .addend_o (addend_w)
    );

    tod_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_w),
        .addend   (addend_w),
        .load     (load_w),
        .load_val (load_val_w),
        .count_o  (count_w)
    );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        step,
    input logic [63:0] addend,
    input logic        load,
    input logic [63:0] load_val,
    input logic [63:0] count,
    input logic [31:0] shadow
);
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (count == $past(count) + $past(addend)));

    a_r8_atomic_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    a_r7_low_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !step) |=> (count == $past(count)));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));

    a_r9_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1) |=> (shadow == $past(count[63:32])));

    a_r9_low_data: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1) |=> (reg_rdata == $past(count[31:0])));

    a_r9_high_data: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> (reg_rdata == $past(shadow)));

    a_r3_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3) |=> (reg_rdata == 32'd0));
endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .step      (step_w),
    .addend    (addend_w),
    .load      (load_w),
    .load_val  (load_val_w),
    .count     (count_w),
    .shadow    (shadow_w)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rdata_w;
    logic [31:0] rdata_n;
    int          n_cmp = 0;
    int          n_bad = 0;

    localparam logic [63:0] STEP_W = 64'h6666_6666;
    localparam logic [63:0] STEP_N = 64'h00CC_CCCC;

    typedef struct packed {
        logic [63:0] v;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{v: 64'h0000_0000_0000_0000, n: 16'd0},
        '{v: 64'h0000_0000_0000_0000, n: 16'd10},
        '{v: 64'h0000_0000_FFFF_FFF0, n: 16'd1},
        '{v: 64'hFFFF_FFFF_FFFF_FFFF, n: 16'd1},
        '{v: 64'h1234_5678_9ABC_DEF0, n: 16'd3},
        '{v: 64'h0000_0000_7FFF_FFFF, n: 16'd200}
    };

    always #10 clk = ~clk;

    tod_counter i_tod_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_w)
    );

    tod_counter #(.NARROW(1'b1)) i_tod_counter_narrow (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the access happens at the next posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] w, output logic [31:0] n);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        w = rdata_w; n = rdata_n;
    endtask

    task automatic load64(input logic [63:0] v);
        wr(2'd1, v[31:0]);
        wr(2'd2, v[63:32]);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] w, n;
        logic [63:0] ew, en;
        repeat (3) @(negedge clk);
        chk("R1 rdata after reset wide", rdata_w, 32'h0);
        chk("R1 rdata after reset narrow", rdata_n, 32'h0);
        rst_n = 1'b1;
        rd(2'd1, w, n);
        chk("R1 count low at reset wide", w, 32'h0);
        chk("R1 count low at reset narrow", n, 32'h0);
        rd(2'd2, w, n);
        chk("R1 count high at reset wide", w, 32'h0);
        chk("R1 count high at reset narrow", n, 32'h0);
        rd(2'd0, w, n);
        chk("R1 step reset wide", w, 32'h6666_6666);
        chk("R1 step reset narrow", n, 32'h01CC_CCCC);

        // Table walk: R2 advance, carry and 64-bit wrap; R8 load; R9 read pair.
        foreach (VECS[i]) begin
            load64(VECS[i].v);
            repeat (int'(VECS[i].n)) @(negedge clk);
            ew = VECS[i].v + 64'(VECS[i].n) * STEP_W;
            en = VECS[i].v + 64'(VECS[i].n) * STEP_N;
            rd(2'd1, w, n);
            chk($sformatf("R2 vec%0d low wide", i), w, ew[31:0]);
            chk($sformatf("R2 vec%0d low narrow", i), n, en[31:0]);
            rd(2'd2, w, n);
            chk($sformatf("R9 vec%0d high wide", i), w, ew[63:32]);
            chk($sformatf("R9 vec%0d high narrow", i), n, en[63:32]);
        end

        // R9: the shadow keeps the high half frozen while the count carries.
        load64(64'h0000_0000_F000_0000);
        rd(2'd1, w, n);
        chk("R9 low before carry wide", w, 32'hF000_0000);
        repeat (5) @(negedge clk);
        rd(2'd2, w, n);
        chk("R9 shadow after carry wide", w, 32'h0);
        chk("R9 shadow narrow", n, 32'h0);

        // R6: a step rewrite keeps the count; the old step applies in the write cycle.
        // R5: the narrow period field becomes 0, so the narrow count freezes.
        load64(64'h0);
        wr(2'd0, 32'h0000_0010);
        rd(2'd1, w, n);
        chk("R6 old step in write cycle wide", w, 32'h6666_6666);
        chk("R6 old step in write cycle narrow", n, 32'h00CC_CCCC);
        rd(2'd2, w, n);
        rd(2'd1, w, n);
        chk("R6 new step applies wide", w, 32'h6666_6686);
        chk("R5 period zero holds narrow", n, 32'h00CC_CCCC);

        // R7: a low write is only staged. R3: an address-3 write is ignored and reads 0.
        wr(2'd1, 32'hAAAA_5555);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, w, n);
        chk("R7 low write leaves count narrow", n, 32'h00CC_CCCC);
        rd(2'd0, w, n);
        chk("R3 addr3 write ignored narrow", n, 32'h0000_0010);
        rd(2'd3, w, n);
        chk("R3 addr3 reads zero wide", w, 32'h0);
        // R8: the high write loads the staged low half.
        wr(2'd2, 32'h0000_0001);
        rd(2'd1, w, n);
        chk("R8 staged low loaded wide", w, 32'hAAAA_5555);
        chk("R8 staged low loaded narrow", n, 32'hAAAA_5555);
        rd(2'd2, w, n);
        chk("R8 high loaded wide", w, 32'h0000_0001);
        chk("R8 high loaded narrow", n, 32'h0000_0001);

        // R4: field layout of the step register.
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, w, n);
        chk("R4 wide drops bit 31", w, 32'h7FFF_FFFF);
        chk("R4 narrow keeps period field", n, 32'hFFFF_FFFF);

        // R5: narrow period 3 with step 0x10.
        wr(2'd0, 32'h0300_0010);
        load64(64'h0);
        rd(2'd1, w, n);
        chk("R8 load then read wide", w, 32'h0);
        chk("R5 period3 first sample narrow", n, 32'h0);
        rd(2'd2, w, n);
        rd(2'd1, w, n);
        chk("R5 period3 one step narrow", n, 32'h0000_0010);
        rd(2'd2, w, n);
        rd(2'd1, w, n);
        chk("R5 period3 two steps narrow", n, 32'h0000_0020);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule